// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block derives two families of slower clocks from one input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth of it. Each bank drives a group of identical true outputs and a matching group of complement outputs. Every divide ratio, including the odd one, gives an output whose high time is exactly half its period. For the odd ratio a half-cycle copy taken on the falling input edge is merged with the rising-edge waveform.

An active-low run request may change at any time. It passes through a short synchronizer. When the request is withdrawn, each bank finishes the period it is in and then rests with true outputs low, so no shortened pulse appears. A new start is granted only once both banks are at rest, so both banks start on the same input edge. An active-high master reset stops everything at once and holds true outputs low. The divide selects are taken only at a period boundary, so a ratio change never cuts a pulse short.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: While `mrst` is 1, every `qa`/`qb` bit is 0 and every `qa_n`/`qb_n` bit is 1, whatever the enable and select inputs are.
- R2: Bank A period is 2 input cycles when `sel_a`=0 and 4 input cycles when `sel_a`=1. The high time is exactly half the period.
- R3: Bank B period follows `sel_b`: 2'b00 gives 4 cycles and 2'b10 gives 6 cycles. The high time is exactly half the period.
- R4: `sel_b` codes 2'b01 and 2'b11 both give a 5-cycle period with a high time of exactly 2.5 input cycles.
- R5: With `clk_en_n`=0 held through reset release, both banks' first rising output edges fall on the same input rising edge. That edge is the (SYNC_STAGES+2)th rising edge after `mrst` falls.
- R6: After `clk_en_n` goes to 1, each bank completes its current period and then stops, with true outputs resting 0 and complements resting 1. No high pulse is ever shorter than the selected half period.
- R7: When `clk_en_n` returns to 0 with both banks stopped, both banks restart on the same input rising edge. That edge is the (SYNC_STAGES+2)th rising edge after the change.
- R8: A select change while running takes effect at that bank's next period boundary. Every high and low pulse has the length of either the old ratio or the new one.
- R9: All true outputs of a bank are identical, and each complement output is the exact inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mrst | input | 1 | Master reset, active high, asynchronous assertion |
| clk_en_n | input | 1 | Run request, active low, may change asynchronously |
| sel_a | input | 1 | Bank A ratio: 0 gives /2, 1 gives /4 |
| sel_b | input | 2 | Bank B ratio: 00 gives /4, 01 gives /5, 10 gives /6, 11 gives /5 |
| qa | output | N_OUT | Bank A true outputs |
| qa_n | output | N_OUT | Bank A complement outputs |
| qb | output | N_OUT | Bank B true outputs |
| qb_n | output | N_OUT | Bank B complement outputs |

## Verification
The assertions assume that the run request and the selects change away from the rising input edge. They also assume that `mrst` is raised or lowered half a cycle from that edge, so there is no sampling race and no metastable value to model. The bench drives every input change at a falling edge or a few nanoseconds after a rising edge. Before each restart it waits long enough for both banks to reach rest, which is the condition under which in-phase start is promised. It also holds the selects steady through reset release, so the first period of each sweep point uses the intended ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int NUM_BANKS = 2;
   localparam int BANK_A    = 0;
   localparam int BANK_B    = 1;

   // larger of two integers
   function automatic int max2(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   // bits needed to hold the value m
   function automatic int bits_for(input int m);
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction

   // nonzero when the ratio needs the falling-edge half-cycle path
   function automatic bit is_odd(input int d);
      return (d % 2) == 1;
   endfunction

endpackage

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int N_BANK      = 2
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              en_n_async,
   input  logic [N_BANK-1:0] bank_idle,
   output logic              go
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   run;
   logic                   go_q;

   // synchronizer: resets to "disabled"
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], en_n_async};
      end
   end

   assign run = ~sync_q[SYNC_STAGES-1];

   // a fresh start is granted only when every bank is at rest
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         go_q <= 1'b0;
      end else begin
         go_q <= run & (go_q | (&bank_idle));
      end
   end

   assign go = go_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
   parameter int DIV_W    = 3,
   parameter bit ODD_PATH = 1'b0
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             go,
   input  logic [DIV_W-1:0] div,
   output logic             idle,
   output logic             clk_out
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic             busy_q, busy_d;
   logic             rise_q, rise_d;
   logic [DIV_W-1:0] ph_q, ph_d;
   logic [DIV_W-1:0] div_q, div_d;
   logic             at_end;

   always_comb begin
      at_end = busy_q && (ph_q == (div_q - ONE));
      busy_d = busy_q;
      ph_d   = ph_q + ONE;
      div_d  = div_q;
      if (!busy_q || at_end) begin
         // period boundary: pick up the ratio or come to rest
         ph_d   = '0;
         busy_d = go;
         if (go) begin
            div_d = div;
         end
      end
      rise_d = busy_d && (ph_d < (div_d >> 1));
   end

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         busy_q <= 1'b0;
         ph_q   <= '0;
         div_q  <= '0;
         rise_q <= 1'b0;
      end else begin
         busy_q <= busy_d;
         ph_q   <= ph_d;
         div_q  <= div_d;
         rise_q <= rise_d;
      end
   end

   assign idle = ~busy_q;

   generate
      if (ODD_PATH) begin : g_odd
         logic fall_q;
         // half-cycle stretch, active only for an odd ratio
         always_ff @(negedge clk or posedge mrst) begin
            if (mrst) begin
               fall_q <= 1'b0;
            end else begin
               fall_q <= rise_q & div_q[0];
            end
         end
         assign clk_out = rise_q | fall_q;
      end else begin : g_even
         assign clk_out = rise_q;
      end
   endgenerate

endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv #(
   parameter int N_OUT       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_A0      = 2,
   parameter int DIV_A1      = 4,
   parameter int DIV_B0      = 4,
   parameter int DIV_B1      = 5,
   parameter int DIV_B2      = 6,
   parameter int DIV_B3      = 5
) (
   input  logic             clk_in,
   input  logic             mrst,
   input  logic             clk_en_n,
   input  logic             sel_a,
   input  logic [1:0]       sel_b,
   output logic [N_OUT-1:0] qa,
   output logic [N_OUT-1:0] qa_n,
   output logic [N_OUT-1:0] qb,
   output logic [N_OUT-1:0] qb_n
);
   import clkdiv_pkg::*;

   localparam int MAX_A = max2(DIV_A0, DIV_A1);
   localparam int MAX_B = max2(max2(DIV_B0, DIV_B1), max2(DIV_B2, DIV_B3));
   localparam int DIV_W = bits_for(max2(MAX_A, MAX_B));
   localparam bit ODD_A = is_odd(DIV_A0) | is_odd(DIV_A1);
   localparam bit ODD_B = is_odd(DIV_B0) | is_odd(DIV_B1) |
                          is_odd(DIV_B2) | is_odd(DIV_B3);

   generate
      if (DIV_A0 < 2 || DIV_A1 < 2 || DIV_B0 < 2 ||
          DIV_B1 < 2 || DIV_B2 < 2 || DIV_B3 < 2) begin : g_bad_div
         $error("dual_bank_clkdiv: every ratio must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dual_bank_clkdiv: SYNC_STAGES must be at least 2");
      end
      if (N_OUT < 1) begin : g_bad_nout
         $error("dual_bank_clkdiv: N_OUT must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0]     div_a, div_b;
   logic [NUM_BANKS-1:0] idle_v;
   logic                 go;
   logic                 a_clk, b_clk;

   assign div_a = sel_a ? DIV_W'(DIV_A1) : DIV_W'(DIV_A0);

   always_comb begin
      case (sel_b)
         2'b00:   div_b = DIV_W'(DIV_B0);
         2'b01:   div_b = DIV_W'(DIV_B1);
         2'b10:   div_b = DIV_W'(DIV_B2);
         default: div_b = DIV_W'(DIV_B3);
      endcase
   end

   clkdiv_gate #(
      .SYNC_STAGES (SYNC_STAGES),
      .N_BANK      (NUM_BANKS)
   ) u_gate (
      .clk        (clk_in),
      .mrst       (mrst),
      .en_n_async (clk_en_n),
      .bank_idle  (idle_v),
      .go         (go)
   );

   clkdiv_bank #(
      .DIV_W    (DIV_W),
      .ODD_PATH (ODD_A)
   ) u_bank_a (
      .clk     (clk_in),
      .mrst    (mrst),
      .go      (go),
      .div     (div_a),
      .idle    (idle_v[BANK_A]),
      .clk_out (a_clk)
   );

   clkdiv_bank #(
      .DIV_W    (DIV_W),
      .ODD_PATH (ODD_B)
   ) u_bank_b (
      .clk     (clk_in),
      .mrst    (mrst),
      .go      (go),
      .div     (div_b),
      .idle    (idle_v[BANK_B]),
      .clk_out (b_clk)
   );

   assign qa   = {N_OUT{a_clk}};
   assign qa_n = {N_OUT{~a_clk}};
   assign qb   = {N_OUT{b_clk}};
   assign qb_n = {N_OUT{~b_clk}};

endmodule

// File: rtl/dual_bank_clkdiv_chk.sv
module dual_bank_clkdiv_chk #(
   parameter int N_OUT = 2
) (
   input logic             clk_in,
   input logic             mrst,
   input logic [N_OUT-1:0] qa,
   input logic [N_OUT-1:0] qa_n,
   input logic [N_OUT-1:0] qb,
   input logic [N_OUT-1:0] qb_n
);

   logic [1:0] a_hi, b_hi;
   logic       a_seen;

   // count rising-edge samples while each bank is high
   always_ff @(posedge clk_in or posedge mrst) begin
      if (mrst) begin
         a_hi   <= 2'd0;
         b_hi   <= 2'd0;
         a_seen <= 1'b0;
      end else begin
         a_hi <= qa[0] ? ((a_hi == 2'd3) ? a_hi : a_hi + 2'd1) : 2'd0;
         b_hi <= qb[0] ? ((b_hi == 2'd3) ? b_hi : b_hi + 2'd1) : 2'd0;
         if (qa[0]) begin
            a_seen <= 1'b1;
         end
      end
   end

   // R1
   always @(posedge clk_in) begin
      if (mrst) begin
         reset_low_chk: assert (qa == '0 && qb == '0 && qa_n == '1 && qb_n == '1);
      end
   end

   // R9
   cmpl_chk: assert property (@(posedge clk_in) disable iff (mrst)
      (qa_n == ~qa) && (qb_n == ~qb));

   // R9
   twin_chk: assert property (@(posedge clk_in) disable iff (mrst)
      (qa == {N_OUT{qa[0]}}) && (qb == {N_OUT{qb[0]}}));

   // R2
   a_high_len_chk: assert property (@(posedge clk_in) disable iff (mrst)
      (!qa[0] && a_hi != 2'd0) |-> (a_hi == 2'd1 || a_hi == 2'd2));

   // R3
   b_high_len_chk: assert property (@(posedge clk_in) disable iff (mrst)
      (!qb[0] && b_hi != 2'd0) |-> (b_hi == 2'd2 || b_hi == 2'd3));

   // R5
   first_phase_chk: assert property (@(posedge clk_in) disable iff (mrst)
      ($rose(qa[0]) && !a_seen) |-> $rose(qb[0]));

endmodule

bind dual_bank_clkdiv dual_bank_clkdiv_chk #(.N_OUT(N_OUT)) u_chk (
   .clk_in (clk_in),
   .mrst   (mrst),
   .qa     (qa),
   .qa_n   (qa_n),
   .qb     (qb),
   .qb_n   (qb_n)
);

// File: tb/dual_bank_clkdiv_test.sv
module dual_bank_clkdiv_test;

   localparam int SYNC = 2;
   localparam int NO   = 2;

   logic          clk_in = 1'b0;
   logic          mrst = 1'b1;
   logic          clk_en_n = 1'b0;
   logic          sel_a = 1'b0;
   logic [1:0]    sel_b = 2'b00;
   logic [NO-1:0] qa, qa_n, qb, qb_n;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   int    pe_cnt = 0;
   bit    mon_on = 1'b0;
   bit    strict_lo = 1'b1;
   bit    lvl [2];
   int    rl [2];
   bit    vld [2];
   int    npl [2];
   int    al1 [2];
   int    al2 [2];
   string tg [2];
   int    arm_pe = 0;
   int    first [2];

   dual_bank_clkdiv #(.N_OUT(NO), .SYNC_STAGES(SYNC)) uut (
      .clk_in   (clk_in),
      .mrst     (mrst),
      .clk_en_n (clk_en_n),
      .sel_a    (sel_a),
      .sel_b    (sel_b),
      .qa       (qa),
      .qa_n     (qa_n),
      .qb       (qb),
      .qb_n     (qb_n)
   );

   initial forever #10 clk_in = ~clk_in;

   task automatic tally(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic sample(input bit at_pos);
      bit v [2];
      v[0] = qa[0];
      v[1] = qb[0];
      if (at_pos) pe_cnt++;
      if (!mrst) begin
         tally((qa_n == ~qa) && (qb_n == ~qb), "R9", "complement",
               int'({qb_n, qa_n}), int'({~qb, ~qa}));
         tally((qa == {NO{qa[0]}}) && (qb == {NO{qb[0]}}), "R9", "twin outputs",
               int'({qb, qa}), int'({{NO{qb[0]}}, {NO{qa[0]}}}));
      end
      for (int i = 0; i < 2; i++) begin
         if (at_pos && first[i] < 0 && v[i]) first[i] = pe_cnt - arm_pe;
         if (v[i] != lvl[i]) begin
            if (mon_on && vld[i]) begin
               if (lvl[i]) begin
                  tally(rl[i] == al1[i] || rl[i] == al2[i], tg[i], "high half-cycles",
                        rl[i], al1[i]);
               end else if (strict_lo) begin
                  tally(rl[i] == al1[i] || rl[i] == al2[i], tg[i], "low half-cycles",
                        rl[i], al1[i]);
               end else begin
                  tally(rl[i] >= ((al1[i] < al2[i]) ? al1[i] : al2[i]), tg[i],
                        "low half-cycles min", rl[i], al1[i]);
               end
            end
            if (!lvl[i]) npl[i]++;
            vld[i] = mon_on;
            rl[i]  = 1;
         end else begin
            rl[i]++;
         end
         lvl[i] = v[i];
      end
   endtask

   initial begin
      lvl = '{1'b0, 1'b0};
      rl  = '{0, 0};
      vld = '{1'b0, 1'b0};
      npl = '{0, 0};
      first = '{-1, -1};
      forever begin
         @(posedge clk_in);
         #5 sample(1'b1);
         @(negedge clk_in);
         #5 sample(1'b0);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk_in);
   endtask

   task automatic set_allow(input int a1, input int a2, input int b1, input int b2);
      al1[0] = a1; al2[0] = a2; al1[1] = b1; al2[1] = b2;
      vld = '{1'b0, 1'b0};
   endtask

   task automatic arm();
      arm_pe = pe_cnt;
      first  = '{-1, -1};
      npl    = '{0, 0};
   endtask

   task automatic check_rest(input string req);
      @(negedge clk_in);
      #5;
      tally(qa == '0 && qb == '0, req, "true outputs at rest", int'({qb, qa}), 0);
      tally(qa_n == '1 && qb_n == '1, req, "complements at rest",
            int'({qb_n, qa_n}), int'({2 * NO{1'b1}}));
   endtask

   function automatic int b_ratio(input int s);
      return (s == 0) ? 4 : (((s % 2) == 1) ? 5 : 6);
   endfunction

   initial begin
      int p;
      int na, nb;
      // R1: reset holds outputs regardless of enable and selects
      for (int c = 0; c < 16; c++) begin
         @(negedge clk_in);
         sel_a    = c[0];
         sel_b    = c[2:1];
         clk_en_n = c[3];
         wait_cyc(3);
         check_rest("R1");
      end

      // R2, R3, R4, R5: every select combination from reset release
      for (int sa = 0; sa < 2; sa++) begin
         for (int sb = 0; sb < 4; sb++) begin
            mon_on = 1'b0;
            @(negedge clk_in);
            mrst = 1'b1;
            sel_a = sa[0];
            sel_b = sb[1:0];
            clk_en_n = 1'b0;
            wait_cyc(3);
            na = (sa == 1) ? 4 : 2;
            nb = b_ratio(sb);
            tg[0] = "R2";
            tg[1] = (nb == 5) ? "R4" : "R3";
            strict_lo = 1'b1;
            set_allow(na, na, nb, nb);
            mon_on = 1'b1;
            @(negedge clk_in);
            mrst = 1'b0;
            arm();
            wait_cyc(100);
            tally(first[0] == SYNC + 2, "R5", "bank A first rise edge", first[0], SYNC + 2);
            tally(first[1] == SYNC + 2, "R5", "bank B first rise edge", first[1], SYNC + 2);
            tally(npl[0] >= 5, "R2", "bank A pulse count", npl[0], 5);
            tally(npl[1] >= 5, tg[1], "bank B pulse count", npl[1], 5);
         end
      end

      // R6, R7: stop at several phases, then restart
      mon_on = 1'b0;
      @(negedge clk_in);
      mrst = 1'b1;
      sel_a = 1'b1;
      sel_b = 2'b01;
      wait_cyc(3);
      tg[0] = "R6";
      tg[1] = "R6";
      strict_lo = 1'b0;
      set_allow(4, 4, 5, 5);
      mon_on = 1'b1;
      @(negedge clk_in);
      mrst = 1'b0;
      arm();
      wait_cyc(30);
      for (int k = 0; k < 6; k++) begin
         @(posedge clk_in);
         #(3 + k) clk_en_n = 1'b1;
         wait_cyc(40);
         check_rest("R6");
         p = npl[0] + npl[1];
         wait_cyc(20);
         tally(npl[0] + npl[1] == p, "R6", "no pulse while stopped", npl[0] + npl[1], p);
         check_rest("R6");
         @(negedge clk_in);
         clk_en_n = 1'b0;
         arm();
         wait_cyc(15);
         tally(first[0] == SYNC + 2, "R7", "bank A restart edge", first[0], SYNC + 2);
         tally(first[1] == SYNC + 2, "R7", "bank B restart edge", first[1], SYNC + 2);
         wait_cyc(7 + 3 * k);
      end

      // R8: select changes while running
      mon_on = 1'b0;
      @(negedge clk_in);
      mrst = 1'b1;
      sel_a = 1'b0;
      sel_b = 2'b00;
      wait_cyc(3);
      tg[0] = "R8";
      tg[1] = "R8";
      strict_lo = 1'b1;
      set_allow(2, 2, 4, 4);
      mon_on = 1'b1;
      @(negedge clk_in);
      mrst = 1'b0;
      arm();
      wait_cyc(31);
      set_allow(2, 4, 4, 6);
      @(posedge clk_in);
      #3;
      sel_a = 1'b1;
      sel_b = 2'b10;
      wait_cyc(40);
      set_allow(4, 4, 6, 6);
      npl = '{0, 0};
      wait_cyc(60);
      tally(npl[0] >= 10, "R8", "bank A pulses after change", npl[0], 10);
      tally(npl[1] >= 8, "R8", "bank B pulses after change", npl[1], 8);
      set_allow(4, 4, 6, 5);
      @(posedge clk_in);
      #7;
      sel_b = 2'b11;
      wait_cyc(40);
      set_allow(4, 4, 5, 5);
      npl = '{0, 0};
      wait_cyc(60);
      tally(npl[1] >= 10, "R8", "bank B pulses at /5", npl[1], 10);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_in);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule